// File: doc/BRIEF.md
# Scrambled 64/67 Line Codec with Disparity Control

This block turns 64-bit words into 67-bit line blocks for a serial lane, and turns such blocks back into words. Each block carries a 3-bit header and a 64-bit payload. Two header bits mark the block as data or control. The third bit records whether the payload was sent complemented. Before the invert decision, the encoder whitens the payload with an additive keystream from a 58-stage linear feedback register. The register is never fed from the line, so one flipped line bit damages exactly one decoded bit.

The encoder keeps a signed running disparity of the line: ones minus zeros over every header and payload bit it has sent. For each block it complements the payload when doing so moves that total back toward zero. On request it emits a sync word, which is a control block that carries the current keystream register state in clear. The decoder restores the payload polarity and checks the type code. It loads its own keystream register from sync words and strips the keystream from all other blocks.

Encoder and decoder share no state. A system wires the encoder output to a serializer and feeds the decoder from the deserializer after block alignment.

Top module: `lane67_codec`

## Requirements
- R1: Every accepted word (`tx_valid` high at a clock edge) yields exactly one block, with `enc_valid` high on the following cycle and low otherwise. Block bit 66 is the invert flag, bits 65:64 the type (01 data, 10 control), bits 63:0 the payload.
- R2: The keystream comes from a 58-bit register s that steps 64 times per block: fb = s[57] ^ s[38], then s = {s[56:0], fb}. This implements x^58 + x^39 + 1. The first fb of a block is XORed into payload bit 63, the last into bit 0. Data blocks are whitened on all 64 bits. Control blocks are whitened on bits 57:0 only, and bits 63:58 stay clear. The register advances once per data or control block.
- R3: When `tx_sync` is high, the block is a control block with payload {SYNC_TAG, current register state}. It is not whitened, and the register does not advance. `tx_data` and `tx_ctrl` have no effect on it. Control words must not carry SYNC_TAG in bits 63:58.
- R4: Let d = 2·(ones in the whitened payload) − 65, the disparity the block has if sent uncomplemented. The payload and the invert flag are complemented exactly when the running disparity is nonzero and has the same sign as d. The sent block's disparity is then added to the running total.
- R5: The running disparity of the emitted line stream never leaves the range −65..+65.
- R6: After reset, no output strobe is high, the running disparity is zero, and both keystream registers hold SEED.
- R7: The decoder complements the payload when bit 66 is set, strips the keystream (same masking as R2) and presents the word with `dec_ctrl` on `dec_valid` one cycle after `rx_valid`.
- R8: A control block whose restored payload bits 63:58 equal SYNC_TAG loads payload bits 57:0 into the decoder register. It pulses `dec_sync` and produces no `dec_valid`.
- R9: A block with type 00 or 11 pulses `dec_type_err`, produces no `dec_valid`, and leaves the decoder register unchanged.
- R10: A single flipped payload bit on the line changes exactly that same bit of the decoded word and no later word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Word offered to the encoder this cycle |
| tx_ctrl | input | 1 | Word is a control word |
| tx_sync | input | 1 | Emit a sync word instead of the offered word |
| tx_data | input | 64 | Word to encode |
| enc_valid | output | 1 | Encoded block valid |
| enc_block | output | 67 | Encoded line block |
| rx_valid | input | 1 | Received block valid |
| rx_block | input | 67 | Received line block |
| dec_valid | output | 1 | Decoded word valid |
| dec_ctrl | output | 1 | Decoded word is a control word |
| dec_data | output | 64 | Decoded word |
| dec_sync | output | 1 | Sync word loaded the decoder register |
| dec_type_err | output | 1 | Received block had an illegal type code |

## Verification
Plain data words of varied content check the header layout and the keystream ordering. Control words show that their top six bits go out in clear. Payloads forced by the bench to all ones, all zeros or exactly balanced drive the running disparity to both signs and to zero, so the invert rule is checked against each sign combination and against the line total bound. Blocks injected straight into the decoder, with illegal types, an inverted sync word, an inverted control word and a single flipped bit, separate the polarity restore, the register reload and the absence of error spreading. A final resync through the encoder shows the loopback path recover.

// File: rtl/lane67_pkg.sv
package lane67_pkg;
  localparam int PAY_W   = 64;
  localparam int SCR_W   = 58;
  localparam int SCR_TAP = 39;
  localparam int TAG_W   = PAY_W - SCR_W;
  localparam int HDR_W   = 3;
  localparam int BLK_W   = PAY_W + HDR_W;
  localparam int INV_BIT = BLK_W - 1;
  localparam int CNT_W   = $clog2(PAY_W) + 1;

  localparam logic [1:0] TY_DATA = 2'b01;
  localparam logic [1:0] TY_CTRL = 2'b10;

  // control blocks keep their top tag field in clear
  localparam logic [PAY_W-1:0] CTRL_MASK = {{TAG_W{1'b0}}, {SCR_W{1'b1}}};

  typedef struct packed {
    logic [SCR_W-1:0] nxt;
    logic [PAY_W-1:0] key;
  } scr_out_t;

  // 64 serial steps of the x^58 + x^39 + 1 generator, first bit lands on MSB
  function automatic scr_out_t scr_run(input logic [SCR_W-1:0] s);
    scr_out_t r;
    logic [SCR_W-1:0] st;
    logic fb;
    st = s;
    r.key = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb = st[SCR_W-1] ^ st[SCR_TAP-1];
      r.key[i] = fb;
      st = {st[SCR_W-2:0], fb};
    end
    r.nxt = st;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] pop_count(input logic [PAY_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < PAY_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/lane67_scrambler.sv
module lane67_scrambler
  import lane67_pkg::*;
#(
  parameter logic [SCR_W-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  input  logic [SCR_W-1:0] load_val,
  output logic [SCR_W-1:0] state,
  output logic [PAY_W-1:0] key
);
  logic [SCR_W-1:0] state_q;
  scr_out_t         run;

  always_comb run = scr_run(state_q);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED;
    else if (load) state_q <= load_val;
    else if (adv)  state_q <= run.nxt;
  end

  assign state = state_q;
  assign key   = run.key;

  // R2: the register moves only on a block step or a load
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> $stable(state_q));
endmodule

// File: rtl/lane67_disparity.sv
module lane67_disparity
  import lane67_pkg::*;
#(
  parameter int RD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [PAY_W-1:0] payload,
  output logic             invert
);
  localparam int RD_LIM = PAY_W + 1;

  logic signed [RD_W-1:0] rd_q;
  logic signed [RD_W-1:0] d_plain;
  logic signed [RD_W-1:0] d_sent;
  int                     d_int;

  always_comb begin
    // header of an uninverted block contributes -1 (flag 0, type balanced)
    d_int   = 2 * int'(pop_count(payload)) - (PAY_W + 1);
    d_plain = RD_W'(d_int);
    invert  = (rd_q != 0) && ((d_plain < 0) == (rd_q < 0));
    d_sent  = invert ? -d_plain : d_plain;
  end

  always_ff @(posedge clk) begin
    if (rst)       rd_q <= '0;
    else if (step) rd_q <= rd_q + d_sent;
  end

  // R5: running total stays within one block of balance
  a_r5_rd_bounded: assert property (@(posedge clk) disable iff (rst)
    (rd_q <= RD_LIM) && (rd_q >= -RD_LIM));

  // R4: an inverting step never moves the total away from zero
  a_r4_no_growth: assert property (@(posedge clk) disable iff (rst)
    (step && invert && rd_q > 0) |=> (rd_q <= $past(rd_q)));
endmodule

// File: rtl/lane67_encoder.sv
module lane67_encoder
  import lane67_pkg::*;
#(
  parameter logic [SCR_W-1:0] SEED     = '1,
  parameter logic [TAG_W-1:0] SYNC_TAG = '1,
  parameter int               RD_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_valid,
  input  logic             tx_ctrl,
  input  logic             tx_sync,
  input  logic [PAY_W-1:0] tx_data,
  output logic             enc_valid,
  output logic [BLK_W-1:0] enc_block
);
  logic [SCR_W-1:0] scr_state;
  logic [PAY_W-1:0] scr_key;
  logic [PAY_W-1:0] pl_pre;
  logic [1:0]       ty;
  logic             inv;

  lane67_scrambler #(.SEED(SEED)) u_scr (
    .clk      (clk),
    .rst      (rst),
    .adv      (tx_valid && !tx_sync),
    .load     (1'b0),
    .load_val ('0),
    .state    (scr_state),
    .key      (scr_key)
  );

  always_comb begin
    if (tx_sync) begin
      ty     = TY_CTRL;
      pl_pre = {SYNC_TAG, scr_state};
    end else if (tx_ctrl) begin
      ty     = TY_CTRL;
      pl_pre = tx_data ^ (scr_key & CTRL_MASK);
    end else begin
      ty     = TY_DATA;
      pl_pre = tx_data ^ scr_key;
    end
  end

  lane67_disparity #(.RD_W(RD_W)) u_disp (
    .clk     (clk),
    .rst     (rst),
    .step    (tx_valid),
    .payload (pl_pre),
    .invert  (inv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_valid <= 1'b0;
      enc_block <= '0;
    end else begin
      enc_valid <= tx_valid;
      if (tx_valid) enc_block <= {inv, ty, inv ? ~pl_pre : pl_pre};
    end
  end

  // R1: one block per accepted word, one cycle later
  a_r1_block_follows: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> enc_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |=> !enc_valid);
  a_r1_type_legal: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> (enc_block[PAY_W+1] != enc_block[PAY_W]));
  // R3: sync word carries the tag in clear and freezes the register
  a_r3_sync_tag: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_sync) |=>
      ((enc_block[PAY_W-1 -: TAG_W] ^ {TAG_W{enc_block[INV_BIT]}}) == SYNC_TAG));
  a_r3_sync_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_sync) |=> $stable(scr_state));
endmodule

// File: rtl/lane67_decoder.sv
module lane67_decoder
  import lane67_pkg::*;
#(
  parameter logic [SCR_W-1:0] SEED     = '1,
  parameter logic [TAG_W-1:0] SYNC_TAG = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [BLK_W-1:0] rx_block,
  output logic             dec_valid,
  output logic             dec_ctrl,
  output logic [PAY_W-1:0] dec_data,
  output logic             dec_sync,
  output logic             dec_type_err
);
  logic [SCR_W-1:0] scr_state;
  logic [PAY_W-1:0] scr_key;
  logic [1:0]       ty;
  logic [PAY_W-1:0] pl;
  logic [PAY_W-1:0] clear;
  logic             legal;
  logic             is_sync;
  logic             adv;
  logic             load;

  always_comb begin
    ty      = rx_block[PAY_W +: 2];
    pl      = rx_block[INV_BIT] ? ~rx_block[PAY_W-1:0] : rx_block[PAY_W-1:0];
    legal   = (ty == TY_DATA) || (ty == TY_CTRL);
    is_sync = (ty == TY_CTRL) && (pl[PAY_W-1 -: TAG_W] == SYNC_TAG);
    clear   = pl ^ ((ty == TY_CTRL) ? (scr_key & CTRL_MASK) : scr_key);
    adv     = rx_valid && legal && !is_sync;
    load    = rx_valid && is_sync;
  end

  lane67_scrambler #(.SEED(SEED)) u_scr (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .load     (load),
    .load_val (pl[SCR_W-1:0]),
    .state    (scr_state),
    .key      (scr_key)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid    <= 1'b0;
      dec_ctrl     <= 1'b0;
      dec_data     <= '0;
      dec_sync     <= 1'b0;
      dec_type_err <= 1'b0;
    end else begin
      dec_valid    <= adv;
      dec_sync     <= load;
      dec_type_err <= rx_valid && !legal;
      if (adv) begin
        dec_ctrl <= (ty == TY_CTRL);
        dec_data <= clear;
      end
    end
  end

  // R9: at most one outcome per received block
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec_valid, dec_sync, dec_type_err}));
  a_r9_bad_type: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (rx_block[PAY_W+1] == rx_block[PAY_W])) |=>
      (dec_type_err && !dec_valid && $stable(scr_state)));
  // R8: sync word payload becomes the register state
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && is_sync) |=> (dec_sync && scr_state == $past(pl[SCR_W-1:0])));
endmodule

// File: rtl/lane67_codec.sv
module lane67_codec
  import lane67_pkg::*;
#(
  parameter logic [SCR_W-1:0] SEED     = 58'h155_5555_AAAA_CC33,
  parameter logic [TAG_W-1:0] SYNC_TAG = 6'b101101,
  parameter int               RD_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_valid,
  input  logic             tx_ctrl,
  input  logic             tx_sync,
  input  logic [PAY_W-1:0] tx_data,
  output logic             enc_valid,
  output logic [BLK_W-1:0] enc_block,
  input  logic             rx_valid,
  input  logic [BLK_W-1:0] rx_block,
  output logic             dec_valid,
  output logic             dec_ctrl,
  output logic [PAY_W-1:0] dec_data,
  output logic             dec_sync,
  output logic             dec_type_err
);
  lane67_encoder #(.SEED(SEED), .SYNC_TAG(SYNC_TAG), .RD_W(RD_W)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_ctrl   (tx_ctrl),
    .tx_sync   (tx_sync),
    .tx_data   (tx_data),
    .enc_valid (enc_valid),
    .enc_block (enc_block)
  );

  lane67_decoder #(.SEED(SEED), .SYNC_TAG(SYNC_TAG)) u_dec (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_block     (rx_block),
    .dec_valid    (dec_valid),
    .dec_ctrl     (dec_ctrl),
    .dec_data     (dec_data),
    .dec_sync     (dec_sync),
    .dec_type_err (dec_type_err)
  );
endmodule

// File: tb/sim_lane67_codec.sv
module sim_lane67_codec;
  import lane67_pkg::*;

  localparam logic [SCR_W-1:0] SEED = 58'h155_5555_AAAA_CC33;
  localparam logic [TAG_W-1:0] TAG  = 6'b101101;

  typedef struct packed {
    logic [1:0]       kind;   // 0 word, 1 sync, 2 type error
    logic             ctrl;
    logic [PAY_W-1:0] data;
  } dexp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             tx_valid = 1'b0, tx_ctrl = 1'b0, tx_sync = 1'b0;
  logic [PAY_W-1:0] tx_data = '0;
  logic             enc_valid;
  logic [BLK_W-1:0] enc_block;
  logic             inj_mode = 1'b0, inj_valid = 1'b0;
  logic [BLK_W-1:0] inj_block = '0;
  logic             rx_valid;
  logic [BLK_W-1:0] rx_block;
  logic             dec_valid, dec_ctrl, dec_sync, dec_type_err;
  logic [PAY_W-1:0] dec_data;

  assign rx_valid = inj_mode ? inj_valid : enc_valid;
  assign rx_block = inj_mode ? inj_block : enc_block;

  lane67_codec #(.SEED(SEED), .SYNC_TAG(TAG), .RD_W(8)) u0 (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_ctrl(tx_ctrl), .tx_sync(tx_sync), .tx_data(tx_data),
    .enc_valid(enc_valid), .enc_block(enc_block),
    .rx_valid(rx_valid), .rx_block(rx_block),
    .dec_valid(dec_valid), .dec_ctrl(dec_ctrl), .dec_data(dec_data),
    .dec_sync(dec_sync), .dec_type_err(dec_type_err)
  );

  int n_chk = 0, n_err = 0, cyc = 0, line_rd = 0;
  bit done = 1'b0;

  logic [SCR_W-1:0] me = SEED, md = SEED;
  int               mrd = 0;
  logic [BLK_W-1:0] qe[$];
  string            qe_t[$];
  dexp_t            qd[$];
  string            qd_t[$];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // independent keystream model: walk the generator bit by bit
  task automatic model_key(input logic [SCR_W-1:0] s, output logic [PAY_W-1:0] k,
                           output logic [SCR_W-1:0] nx);
    logic [SCR_W-1:0] r;
    logic b;
    r = s;
    for (int j = 0; j < PAY_W; j++) begin
      b = r[57] ^ r[38];
      k[PAY_W-1-j] = b;
      r = {r[56:0], b};
    end
    nx = r;
  endtask

  task automatic enc_model(input logic c, input logic s, input logic [PAY_W-1:0] d,
                           output logic [BLK_W-1:0] b);
    logic [PAY_W-1:0] k, p;
    logic [SCR_W-1:0] nx;
    logic [1:0] ty;
    logic iv;
    int dz;
    if (s) begin
      ty = 2'b10;
      p  = {TAG, me};
    end else begin
      model_key(me, k, nx);
      ty = c ? 2'b10 : 2'b01;
      p  = c ? (d ^ {6'b0, k[57:0]}) : (d ^ k);
      me = nx;
    end
    dz  = 2 * $countones(p) - 65;
    iv  = (mrd != 0) && ((dz < 0) == (mrd < 0));
    mrd = mrd + (iv ? -dz : dz);
    b   = {iv, ty, iv ? ~p : p};
  endtask

  task automatic send(input logic c, input logic s, input logic [PAY_W-1:0] d, input string tag);
    logic [BLK_W-1:0] b;
    logic [PAY_W-1:0] k;
    logic [SCR_W-1:0] nx;
    @(negedge clk);
    tx_valid = 1'b1; tx_ctrl = c; tx_sync = s; tx_data = d;
    if (!inj_mode) begin
      if (s) begin
        qd.push_back('{2'd1, 1'b0, 64'd0});
        md = me;
      end else begin
        qd.push_back('{2'd0, c, d});
        model_key(md, k, nx);
        md = nx;
      end
      qd_t.push_back("R7 loopback");
    end
    enc_model(c, s, d, b);
    qe.push_back(b);
    qe_t.push_back(tag);
  endtask

  // choose the word so that the whitened payload equals p
  task automatic send_forced(input logic c, input logic [PAY_W-1:0] p, input string tag);
    logic [PAY_W-1:0] k;
    logic [SCR_W-1:0] nx;
    model_key(me, k, nx);
    send(c, 1'b0, c ? (p ^ {6'b0, k[57:0]}) : (p ^ k), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_valid = 1'b0; tx_sync = 1'b0; tx_ctrl = 1'b0;
      inj_valid = 1'b0;
    end
  endtask

  task automatic inject(input logic [BLK_W-1:0] b, input dexp_t e, input string tag);
    @(negedge clk);
    inj_valid = 1'b1;
    inj_block = b;
    qd.push_back(e);
    qd_t.push_back(tag);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (enc_valid) begin
        if (qe.size() == 0) chk(1'b0, "R1 unexpected block", 128'(enc_block), 128'd0);
        else begin
          logic [BLK_W-1:0] eb;
          string et;
          eb = qe.pop_front();
          et = qe_t.pop_front();
          chk(enc_block === eb, et, 128'(enc_block), 128'(eb));
          line_rd = line_rd + 2 * $countones(enc_block) - BLK_W;
          chk((line_rd <= 65) && (line_rd >= -65), "R5 line disparity",
              128'(unsigned'(line_rd)), 128'd65);
        end
      end
      if (dec_valid || dec_sync || dec_type_err) begin
        logic [1:0] kd;
        kd = dec_type_err ? 2'd2 : (dec_sync ? 2'd1 : 2'd0);
        if (qd.size() == 0) chk(1'b0, "R7 unexpected output", 128'(kd), 128'd0);
        else begin
          dexp_t e;
          string t;
          e = qd.pop_front();
          t = qd_t.pop_front();
          chk((kd == e.kind) && (e.kind != 2'd0 || (dec_ctrl == e.ctrl && dec_data == e.data)),
              t, 128'({kd, dec_ctrl, dec_data}), 128'(e));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 20000);
      report();
    end
  end

  initial begin
    logic [PAY_W-1:0] k, p, clr;
    logic [SCR_W-1:0] nx;
    logic [SCR_W-1:0] xs;
    repeat (3) @(negedge clk);
    // R6: quiet outputs during reset
    chk(!enc_valid && !dec_valid && !dec_sync && !dec_type_err, "R6 reset outputs",
        128'({enc_valid, dec_valid, dec_sync, dec_type_err}), 128'd0);
    rst = 1'b0;

    // R1 / R6: first block uses SEED, plain data words back to back
    send(1'b0, 1'b0, 64'h0, "R6 first block from seed");
    send(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R1 data all ones");
    send(1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, "R1 data mixed");
    idle(1);
    // R2: control words keep top bits in clear
    send(1'b1, 1'b0, {6'h1E, 58'h2_3456_789A_BCDE}, "R2 control word");
    send(1'b0, 1'b0, 64'hA5A5_5A5A_0F0F_F0F0, "R2 data after control");
    // R3: sync word ignores tx_data and tx_ctrl
    send(1'b1, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF, "R3 sync word");
    send(1'b0, 1'b0, 64'h1111_2222_3333_4444, "R3 register held over sync");
    // R4: skewed and balanced payloads push the total both ways
    send_forced(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R4 all ones payload");
    send_forced(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R4 all ones repeated");
    send_forced(1'b0, 64'h0, "R4 all zeros payload");
    send_forced(1'b0, 64'h0, "R4 all zeros repeated");
    send_forced(1'b0, 64'h0, "R4 all zeros third");
    send_forced(1'b0, 64'hFFFF_FFFF_0000_0000, "R4 balanced payload");
    send_forced(1'b1, {6'h00, 58'h0}, "R4 control zero payload");
    send_forced(1'b0, 64'hFFFF_FFFF_FFFF_FFFE, "R4 near full payload");
    idle(4);

    // direct decoder stimulus
    inj_mode = 1'b1;
    inject({1'b0, 2'b00, 64'hDEAD_0000_BEEF_1111}, '{2'd2, 1'b0, 64'd0}, "R9 type 00");
    inject({1'b1, 2'b11, 64'h0}, '{2'd2, 1'b0, 64'd0}, "R9 type 11");
    model_key(md, k, nx);
    inject({1'b0, 2'b01, 64'hCAFE_F00D_1234_5678 ^ k},
           '{2'd0, 1'b0, 64'hCAFE_F00D_1234_5678}, "R9 register unchanged after errors");
    md = nx;
    xs = 58'h0AB_CDEF_0123_4567;
    p  = {TAG, xs};
    inject({1'b1, 2'b10, ~p}, '{2'd1, 1'b0, 64'd0}, "R8 inverted sync reload");
    md = xs;
    model_key(md, k, nx);
    clr = {6'h15, 58'h1_2345_6789_ABCD};
    p   = clr ^ {6'b0, k[57:0]};
    inject({1'b1, 2'b10, ~p}, '{2'd0, 1'b1, clr}, "R7 inverted control after reload");
    md = nx;
    model_key(md, k, nx);
    clr = 64'h0F1E_2D3C_4B5A_6978;
    p   = (clr ^ k) ^ (64'd1 << 17);
    inject({1'b0, 2'b01, p}, '{2'd0, 1'b0, clr ^ (64'd1 << 17)}, "R10 single bit error");
    md = nx;
    model_key(md, k, nx);
    clr = 64'h7777_0000_8888_FFFF;
    inject({1'b0, 2'b01, clr ^ k}, '{2'd0, 1'b0, clr}, "R10 next word clean");
    md = nx;
    idle(3);
    inj_mode = 1'b0;

    // R8: loopback recovers once a sync word passes
    send(1'b0, 1'b1, 64'h0, "R8 resync word");
    send(1'b0, 1'b0, 64'h5555_AAAA_3333_CCCC, "R8 data after resync");
    send(1'b1, 1'b0, {6'h2A, 58'h0_0000_0000_00FF}, "R8 control after resync");
    idle(5);
    chk((qe.size() == 0) && (qd.size() == 0), "R1 all expected results seen",
        128'(qe.size() + qd.size()), 128'd0);
    report();
  end
endmodule